// File: doc/BRIEF.md
# Block-Write Serial Configuration Register Bank

This block is a two-wire serial slave that stores a small bank of 8-bit configuration registers for clock control logic. It has no register addressing. A write transfer opens with the slave address and then two header bytes, an opcode and a length. Both header bytes are acknowledged and then thrown away. Every byte after the header fills the next register, starting at register 0 and moving strictly upward, until the host ends the transfer. A read transfer returns a length byte first and then registers from 0 upward. The length is whatever the readback-count register holds.

Two register pairs, (11,12) and (13,14), are updated atomically. The low byte of a pair is held aside and commits only when its partner arrives in the same transfer. Register 0 drives the frequency-source decode, the spread enable and the output tristate. Register 7 is read-only and shows the frequency-select pins as sampled during reset, inverted. SCL and SDA are oversampled through synchronizers on a system clock that runs at least 16 times the bit rate. The slave drives SDA only by pulling it low.

Top module: `cfg_i2c_regfile`

## Requirements
- R1: The slave acknowledges the write address D2h and the read address D3h (7-bit address 69h, with R/W in bit 0). Any other address gets no acknowledge, and the rest of that transfer up to the next start changes nothing.
- R2: In a write, the two bytes after the address are acknowledged, and their values never reach any register.
- R3: Data byte k of a write (k = 0, 1, 2, ...) targets register k. Every data byte is acknowledged. Bytes aimed past the last register (index 20 by default) are acknowledged and dropped, and a stop after any whole byte ends the transfer cleanly.
- R4: Register 11 loads only when register 12 is also written in the same transfer, and register 13 only together with register 14. A stop or repeated start after the low byte discards it, and the old value stays.
- R5: A read returns the readback count N first, then registers 0 to N-1, then FFh for every further byte, until the host answers a byte with no acknowledge.
- R6: The readback-count register is register 8. A write of 00h to it is ignored, so it keeps its previous value.
- R7: After reset, register 8 is 08h, registers 1 to 5 are FFh, register 7 shows the latched pins, and every other register is 00h. Writes aimed at register 7 have no effect.
- R8: Register 7 reads {4'b0000, ~fs_latched}. fs_latched is fs_pins sampled while reset is held, and it is frozen once reset is released.
- R9: freq_code is {1'b0, fs_latched} (not inverted) when register 0 bit 3 is 0. When bit 3 is 1, it is {reg0[2], reg0[7:4]}.
- R10: spread_en follows register 0 bit 1, and out_tristate follows register 0 bit 0.
- R11: The slave changes its SDA drive only while SCL is low, so it never creates a false start or stop. It releases SDA after each acknowledge bit and once a transfer ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset; fs_pins are sampled while it is low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| fs_pins | input | 4 | Hardware frequency-select straps |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| cfg_regs | output | NUM_REGS*8 | All register contents; register i is bits [8i+7:8i] |
| freq_code | output | 5 | Selected frequency code |
| spread_en | output | 1 | Spread-spectrum enable |
| out_tristate | output | 1 | Request to float all clock outputs |

## Verification
Full 23-byte block writes are repeated with three arithmetic data seeds. The bytes run past the end of the bank and also land on register 7, the count register and both pairs. This separates correct ascending loading from off-by-one or header-leaking behaviour. Truncated writes stop at 12, 14 and 15 data bytes, and one transfer is cut by a repeated start. These tell a correct atomic pair apart from one that commits half a pair or keeps a stale pending byte. Reads are done with the default count and with a reprogrammed count, which shows whether the length byte, the register order and the FFh tail are right. A sweep of 32 values for register 0, half in hardware mode and half in register mode, covers every branch of the frequency decode and both control bits.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WR,
    ST_ACK,
    ST_RD,
    ST_RACK
  } bus_state_t;

  // Power-on value of register idx.
  function automatic logic [7:0] reg_default(input int idx, input int cnt_idx,
                                             input int en_lo, input int en_hi,
                                             input logic [7:0] cnt_def);
    if (idx == cnt_idx) return cnt_def;
    if (idx >= en_lo && idx <= en_hi) return 8'hFF;
    return 8'h00;
  endfunction

  // Frequency source: pins when sel[3]==0, register field otherwise.
  function automatic logic [4:0] freq_decode(input logic [7:0] sel, input logic [3:0] fs_lat);
    return sel[3] ? {sel[2], sel[7:4]} : {1'b0, fs_lat};
  endfunction

  // Byte to send at read position pos: count first, then registers, then FFh.
  function automatic logic [7:0] tx_pick(input logic [8:0] pos, input logic [7:0] cnt,
                                         input logic [7:0] data);
    if (pos == 9'd0) return cnt;
    if ((pos - 9'd1) < {1'b0, cnt}) return data;
    return 8'hFF;
  endfunction

endpackage

// File: rtl/cfg_i2c_line_sync.sv
module cfg_i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         HDR_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] cnt_val,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] rd_idx,
  output logic       xfer_end
);
  localparam int HW = $clog2(HDR_BYTES + 1);

  bus_state_t    state;
  logic [7:0]    shreg;
  logic [3:0]    bitcnt;
  logic          is_read, mack;
  logic [HW-1:0] hdr_cnt;
  logic [7:0]    wr_ptr;
  logic [8:0]    rd_pos;
  logic [7:0]    nxt_tx;
  logic          addr_hit, byte_rx;

  assign xfer_end = start_det | stop_det;
  assign rd_idx   = rd_pos[7:0] - 8'd1;
  assign nxt_tx   = tx_pick(rd_pos, cnt_val, rd_data);
  assign addr_hit = (shreg[7:1] == DEV_ADDR);
  assign byte_rx  = scl_fall && (bitcnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= 8'h00;
      bitcnt  <= 4'd0;
      is_read <= 1'b0;
      mack    <= 1'b0;
      hdr_cnt <= '0;
      wr_ptr  <= 8'h00;
      rd_pos  <= 9'd0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= 8'h00;
      wr_data <= 8'h00;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bitcnt  <= 4'd0;
        sda_oe  <= 1'b0;
        hdr_cnt <= '0;
        wr_ptr  <= 8'h00;
        rd_pos  <= 9'd0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end
            if (byte_rx) begin
              bitcnt <= 4'd0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  is_read <= shreg[0];
                  sda_oe  <= 1'b1;
                  state   <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                if (hdr_cnt != HW'(HDR_BYTES)) begin
                  hdr_cnt <= hdr_cnt + HW'(1);
                end else begin
                  wr_en   <= 1'b1;
                  wr_idx  <= wr_ptr;
                  wr_data <= shreg;
                  if (wr_ptr != 8'hFF) wr_ptr <= wr_ptr + 8'd1;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= 4'd0;
              if (is_read) begin
                shreg  <= nxt_tx;
                sda_oe <= ~nxt_tx[7];
                if (rd_pos != 9'h1FF) rd_pos <= rd_pos + 9'd1;
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              bitcnt <= 4'd0;
              if (mack) begin
                shreg  <= nxt_tx;
                sda_oe <= ~nxt_tx[7];
                if (rd_pos != 9'h1FF) rd_pos <= rd_pos + 9'd1;
                state  <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: drive changes only follow a low SCL (start/stop excepted)
  assert_no_change_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && !$past(xfer_end)) |-> !$past(scl_s));

  // R1: an idle slave never holds SDA
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R1: a start always re-arms address reception with SDA released
  assert_start_rearms_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR && !sda_oe));

  // R2: no register write until both header bytes have passed
  assert_header_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(hdr_cnt == HW'(HDR_BYTES)));

endmodule

// File: rtl/cfg_i2c_regbank.sv
module cfg_i2c_regbank
  import cfg_i2c_pkg::*;
#(
  parameter int         NUM_REGS    = 21,
  parameter int         CNT_IDX     = 8,
  parameter int         RO_IDX      = 7,
  parameter int         PAIR_A      = 11,
  parameter int         PAIR_B      = 13,
  parameter int         EN_LO       = 1,
  parameter int         EN_HI       = 5,
  parameter logic [7:0] CNT_DEFAULT = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic       xfer_end,
  input  logic [3:0] fs_lat,
  input  logic [7:0] rd_idx,
  output logic [7:0] rd_data,
  output logic [7:0] rq [NUM_REGS]
);
  localparam int IDXW = $clog2(NUM_REGS);

  logic       pend_valid;
  logic [7:0] pend_idx, pend_data;
  logic       is_lo_wr;

  assign is_lo_wr = (wr_idx == 8'(PAIR_A)) || (wr_idx == 8'(PAIR_B));

  // Low half of a pair waits here until its partner arrives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_idx   <= 8'h00;
      pend_data  <= 8'h00;
    end else if (xfer_end) begin
      pend_valid <= 1'b0;
    end else if (wr_en) begin
      pend_valid <= is_lo_wr;
      if (is_lo_wr) begin
        pend_idx  <= wr_idx;
        pend_data <= wr_data;
      end
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == RO_IDX) begin : g_ro
      assign rq[i] = {4'h0, ~fs_lat};
    end else begin : g_rw
      localparam bit IS_LO  = (i == PAIR_A) || (i == PAIR_B);
      localparam bit IS_HI  = (i == PAIR_A + 1) || (i == PAIR_B + 1);
      localparam bit IS_CNT = (i == CNT_IDX);
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= reg_default(i, CNT_IDX, EN_LO, EN_HI, CNT_DEFAULT);
        end else if (wr_en) begin
          if (IS_LO) begin
            if (wr_idx == 8'(i + 1) && pend_valid && pend_idx == 8'(i)) q <= pend_data;
          end else if (IS_HI) begin
            if (wr_idx == 8'(i) && pend_valid && pend_idx == 8'(i - 1)) q <= wr_data;
          end else if (IS_CNT) begin
            if (wr_idx == 8'(i) && wr_data != 8'h00) q <= wr_data;
          end else if (wr_idx == 8'(i)) begin
            q <= wr_data;
          end
        end
      end
      assign rq[i] = q;
    end
  end

  assign rd_data = (int'(rd_idx) < NUM_REGS) ? rq[rd_idx[IDXW-1:0]] : 8'hFF;

  // R4: low half of pair A only moves right after its partner's write
  assert_pair_atomic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rq[PAIR_A] != $past(rq[PAIR_A])) |-> $past(wr_en && wr_idx == 8'(PAIR_A + 1)));

  // R6: readback count is never zero
  assert_count_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rq[CNT_IDX] != 8'h00);

  // R8: the read-only strap image does not move after reset
  assert_ro_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rq[RO_IDX]));

endmodule

// File: rtl/cfg_i2c_regfile.sv
module cfg_i2c_regfile
  import cfg_i2c_pkg::*;
#(
  parameter int         NUM_REGS    = 21,
  parameter int         CNT_IDX     = 8,
  parameter int         RO_IDX      = 7,
  parameter int         PAIR_A      = 11,
  parameter int         PAIR_B      = 13,
  parameter int         EN_LO       = 1,
  parameter int         EN_HI       = 5,
  parameter logic [7:0] CNT_DEFAULT = 8'h08,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2,
  parameter int         HDR_BYTES   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [3:0]            fs_pins,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_regs,
  output logic [4:0]            freq_code,
  output logic                  spread_en,
  output logic                  out_tristate
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en, xfer_end;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;
  logic [7:0] rq [NUM_REGS];
  logic [3:0] fs_lat;

  // Straps are captured for as long as reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) fs_lat <= fs_pins;
  end

  cfg_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfg_i2c_engine #(.DEV_ADDR(DEV_ADDR), .HDR_BYTES(HDR_BYTES)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .cnt_val(rq[CNT_IDX]), .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .xfer_end(xfer_end)
  );

  cfg_i2c_regbank #(
    .NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX), .RO_IDX(RO_IDX), .PAIR_A(PAIR_A),
    .PAIR_B(PAIR_B), .EN_LO(EN_LO), .EN_HI(EN_HI), .CNT_DEFAULT(CNT_DEFAULT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .xfer_end(xfer_end), .fs_lat(fs_lat), .rd_idx(rd_idx), .rd_data(rd_data), .rq(rq)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_flat
    assign cfg_regs[i*8 +: 8] = rq[i];
  end

  assign freq_code    = freq_decode(rq[0], fs_lat);
  assign spread_en    = rq[0][1];
  assign out_tristate = rq[0][0];

endmodule

// File: tb/cfg_i2c_regfile_tb.sv
module cfg_i2c_regfile_tb;
  localparam int N = 21;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [3:0] fs_pins = 4'b1010;
  logic sda_oe;
  logic [N*8-1:0] cfg_regs;
  logic [4:0] freq_code;
  logic spread_en, out_tristate;
  wire sda_line = sda_m & ~sda_oe;

  int n_tests = 0, n_fail = 0, viol = 0;
  logic [7:0] mreg [N];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  cfg_i2c_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .fs_pins(fs_pins),
    .sda_oe(sda_oe), .cfg_regs(cfg_regs), .freq_code(freq_code),
    .spread_en(spread_en), .out_tristate(out_tristate)
  );

  always #5 clk = ~clk;

  // R11 monitor: drive must not move while SCL is high
  always @(sda_oe) if (rst_n && scl) viol++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0;
    end
    wq(); sda_m = ~give_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic write_xfer(input int n, input bit do_stop, output int nacks);
    logic a;
    nacks = 0;
    bus_start();
    send_byte(8'hD2, a); if (!a) nacks++;
    send_byte(8'hA5, a); if (!a) nacks++;
    send_byte(8'h3C, a); if (!a) nacks++;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); if (!a) nacks++;
    end
    if (do_stop) bus_stop();
  endtask

  task automatic read_xfer(input int n, output logic addr_ack);
    bus_start();
    send_byte(8'hD3, addr_ack);
    for (int k = 0; k < n; k++) recv_byte(k < n - 1, rbuf[k]);
    bus_stop();
  endtask

  // Expected effect of n data bytes in one transfer
  task automatic model_write(input int n);
    for (int k = 0; k < n && k < N; k++) begin
      if (k == 7) continue;
      if (k == 8 && wbuf[k] == 8'h00) continue;
      if ((k == 11 || k == 13) && n <= k + 1) continue;
      mreg[k] = wbuf[k];
    end
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < N; i++)
      chk($sformatf("%s reg%0d", tag, i), {24'h0, cfg_regs[i*8 +: 8]}, {24'h0, mreg[i]});
  endtask

  function automatic logic [4:0] exp_freq();
    if (mreg[0][3]) return {mreg[0][2], mreg[0][7:4]};
    return 5'b01010;
  endfunction

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog: actual hung expected done");
    report();
  end

  initial begin
    int nk;
    logic a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    fs_pins = 4'b0101;   // must not be seen after reset (R8)
    wq();

    for (int i = 0; i < N; i++)
      mreg[i] = (i == 8) ? 8'h08 : ((i >= 1 && i <= 5) ? 8'hFF : 8'h00);
    mreg[7] = 8'h05;     // ~4'b1010
    check_regs("R7 reset");
    chk("R8 strap image", {24'h0, cfg_regs[56 +: 8]}, 32'h05);
    chk("R9 pin mode freq", {27'h0, freq_code}, 32'h0A);
    chk("R10 spread reset", {31'h0, spread_en}, 0);
    chk("R10 tristate reset", {31'h0, out_tristate}, 0);

    // R5: default-count read, count + regs 0..7 + FFh tail
    read_xfer(10, a);
    chk("R1 read addr ack", {31'h0, a}, 1);
    chk("R5 count byte", {24'h0, rbuf[0]}, 32'h08);
    for (int k = 0; k < 8; k++)
      chk($sformatf("R5 read reg%0d", k), {24'h0, rbuf[k+1]}, {24'h0, mreg[k]});
    chk("R5 tail FF", {24'h0, rbuf[9]}, 32'hFF);

    // R1: foreign address ignored
    bus_start();
    send_byte(8'hD4, a);
    chk("R1 foreign nack", {31'h0, a}, 0);
    send_byte(8'h00, a);
    send_byte(8'h77, a);
    bus_stop();
    check_regs("R1 foreign ignored");

    // R2 R3: full block writes, three seeds
    foreach (rbuf[s]) if (s < 3) begin
      int seed;
      seed = (s == 0) ? 13 : ((s == 1) ? 101 : 200);
      for (int k = 0; k < 23; k++) wbuf[k] = 8'(k * 37 + seed);
      write_xfer(23, 1'b1, nk);
      chk("R2 and R3 all acked", nk, 0);
      model_write(23);
      check_regs("R3 block");
      chk("R11 released after stop", {31'h0, sda_oe}, 0);
    end

    // R4: truncated transfers around the pairs
    for (int k = 0; k < 23; k++) wbuf[k] = 8'hC0 + 8'(k);
    write_xfer(12, 1'b1, nk); model_write(12); check_regs("R4 lone low A");
    write_xfer(14, 1'b1, nk); model_write(14); check_regs("R4 pair A with lone low B");
    write_xfer(15, 1'b1, nk); model_write(15); check_regs("R4 pair B");

    // R4: repeated start drops pending low byte
    for (int k = 0; k < 23; k++) wbuf[k] = 8'h20 + 8'(k);
    write_xfer(12, 1'b0, nk); model_write(12);
    wbuf[0] = 8'h30;
    write_xfer(1, 1'b1, nk); model_write(1);
    chk("R4 rep start acked", nk, 0);
    check_regs("R4 rep start");

    // R6: zero count write ignored, nonzero accepted
    for (int k = 0; k < 9; k++) wbuf[k] = 8'h40 + 8'(k);
    wbuf[8] = 8'h00;
    write_xfer(9, 1'b1, nk); model_write(9);
    chk("R6 zero ignored", {24'h0, cfg_regs[64 +: 8]}, {24'h0, mreg[8]});
    wbuf[8] = 8'h05;
    write_xfer(9, 1'b1, nk); model_write(9);
    chk("R6 count set", {24'h0, cfg_regs[64 +: 8]}, 32'h05);
    read_xfer(7, a);
    chk("R5 new count byte", {24'h0, rbuf[0]}, 32'h05);
    for (int k = 0; k < 5; k++)
      chk($sformatf("R5 short read reg%0d", k), {24'h0, rbuf[k+1]}, {24'h0, mreg[k]});
    chk("R5 short tail FF", {24'h0, rbuf[6]}, 32'hFF);

    // R9 R10: sweep register 0
    for (int v = 0; v < 32; v++) begin
      logic [4:0] vv;
      vv = 5'(v);
      wbuf[0] = {vv[3:0], vv[4], vv[0], vv[1], vv[2]};
      write_xfer(1, 1'b1, nk); model_write(1);
      chk($sformatf("R9 freq v%0d", v), {27'h0, freq_code}, {27'h0, exp_freq()});
      chk($sformatf("R10 spread v%0d", v), {31'h0, spread_en}, {31'h0, mreg[0][1]});
      chk($sformatf("R10 tristate v%0d", v), {31'h0, out_tristate}, {31'h0, mreg[0][0]});
    end

    chk("R11 no drive change with SCL high", viol, 0);
    report();
  end

endmodule